// File: doc/BRIEF.md
# Parallel NOR Flash Command and Status Engine

This block sits on the device side of a 16-bit parallel NOR flash. It watches single-cycle bus write strobes and recognises the multi-cycle unlock sequences that start a word program, a sector erase, a block erase or a whole-array erase. It also recognises the single-cycle erase suspend and erase resume commands. Once a sequence completes, the engine runs an internal busy phase whose length comes from a cycle counter. During that phase a bus read returns status bits instead of array contents, so software can poll for completion. The array is a small register file that resets to the erased value (all ones). A program can only clear bits: the new word is the old word AND the written data.

The unlock decoder has seven states. D_IDLE moves to D_UNL1 on AAh written to 5555h. D_UNL1 moves to D_UNL2 on 55h written to 2AAAh. D_UNL2 moves to D_PGM on A0h or to D_ERS1 on 80h, both written to 5555h. D_ERS1 moves to D_ERS2 on AAh to 5555h, and D_ERS2 moves to D_ERS3 on 55h to 2AAAh. D_PGM fires a program on any write. D_ERS3 fires a whole-array erase on 10h at 5555h, a sector erase on 30h, or a block erase on 50h; for the last two the write address selects the region. Any other write returns the decoder to D_IDLE.

The operation controller has five states. C_IDLE goes to C_PROG on a program, or to C_ERASE on an erase command (a whole-array erase needs the write-protect pin high). C_PROG returns to C_IDLE when its count expires. C_ERASE returns to C_IDLE on expiry, or goes to C_SUSP on B0h for a sector or block erase. C_SUSP goes back to C_ERASE on 30h, or goes to C_SUSP_PROG on a program outside the suspended region. C_SUSP_PROG returns to C_SUSP when its count expires.

Top module: `flash_cmd_engine`

## Requirements
- R1: The sequence AAh@5555h, 55h@2AAAh, A0h@5555h, then data@address, holds `busy` high with `op_active`=1 for exactly PROG_CYC cycles after the last write. Afterwards the word at address reads as old AND data.
- R2: The sequence AAh, 55h, 80h, AAh, 55h (the AAh/80h writes at 5555h, the 55h writes at 2AAAh), then 30h to an address, holds `busy` high with `op_active`=2 for exactly ERASE_CYC cycles. Afterwards every word of the addressed sector reads FFFFh, and words outside that sector are unchanged. The sector is array index bits [ARR_AW-1 -: SECT_W].
- R3: The same sequence ending with 50h erases the whole block holding the address, with `op_active`=3. The block is the top BLK_W bits of the sector number.
- R4: The same sequence ending with 10h at 5555h erases every word, with `op_active`=4.
- R5: If `wp_n` is low on the final write of a whole-array erase, the request is ignored: `busy` stays low and the array is unchanged.
- R6: A write that does not match the next expected cycle returns the decoder to idle. A later cycle that would have completed the broken sequence has no effect.
- R7: A read during a program returns bit 7 = complement of the data's bit 7, bit 2 = 1, and all other bits 0 except bit 6. Bit 6 is 0 on the first status read of the operation and inverts on each later read.
- R8: A read during a running erase returns bit 7 = 0, with bits 6 and 2 each starting at 0 and inverting on each read. All other bits are 0.
- R9: While a whole-array erase runs, every write is ignored, including suspend and program sequences.
- R10: B0h written during a sector or block erase suspends it. `busy` drops, `susp_active` rises, and `susp_sector` gives the sector. A read inside the suspended region returns bits 7 and 6 = 1 with bit 2 toggling, and a read outside it returns array data.
- R11: 30h written to any address while suspended resumes the erase, which runs only its remaining cycles.
- R12: A program issued while suspended, outside the suspended region, runs with program status (R7) and then returns to suspend. A program aimed inside the region is ignored.
- R13: After reset all words read FFFFh. A read strobe returns the word one cycle later on `bus_rdata` while no operation is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_we | input | 1 | Write strobe, one cycle per bus write |
| bus_re | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Word address for reads and writes |
| bus_wdata | input | 16 | Write data |
| wp_n | input | 1 | Write protect, active low |
| bus_rdata | output | 16 | Registered read data or status |
| busy | output | 1 | Program or erase running |
| op_active | output | 3 | 0 none, 1 program, 2 sector, 3 block, 4 whole array |
| susp_active | output | 1 | An erase is suspended |
| susp_sector | output | SECT_W | Sector of the suspended erase |

## Verification
The hardest situation to reach is a program running inside an erase suspend while the status toggles continue across both operations. The bench starts a sector erase and suspends it after a known number of cycles. It then reads the suspended region twice, tries a program into that region, and runs a program elsewhere with status polling. It resumes with a stray address and checks that the remaining busy time equals the erase length minus the cycles already spent.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

    typedef enum logic [2:0] {
        OP_NONE = 3'd0,
        OP_PROG = 3'd1,
        OP_SECT = 3'd2,
        OP_BLK  = 3'd3,
        OP_CHIP = 3'd4
    } op_e;

    typedef enum logic [2:0] {
        D_IDLE, D_UNL1, D_UNL2, D_PGM, D_ERS1, D_ERS2, D_ERS3
    } dec_e;

    typedef enum logic [2:0] {
        C_IDLE, C_PROG, C_ERASE, C_SUSP, C_SUSP_PROG
    } ctl_e;

    typedef enum logic [1:0] {
        RM_ARRAY, RM_PROG, RM_ERASE, RM_SUSP_HIT
    } rdmode_e;

    localparam logic [15:0] UNLOCK_ADR_A = 16'h5555;
    localparam logic [15:0] UNLOCK_ADR_B = 16'h2AAA;
    localparam logic [7:0]  KEY_A        = 8'hAA;
    localparam logic [7:0]  KEY_B        = 8'h55;
    localparam logic [7:0]  CMD_PROG     = 8'hA0;
    localparam logic [7:0]  CMD_ERS_SET  = 8'h80;
    localparam logic [7:0]  CMD_CHIP     = 8'h10;
    localparam logic [7:0]  CMD_SECT     = 8'h30;
    localparam logic [7:0]  CMD_BLK      = 8'h50;
    localparam logic [7:0]  CMD_SUSPEND  = 8'hB0;
    localparam logic [7:0]  CMD_RESUME   = 8'h30;

endpackage

// File: rtl/fce_seq_decoder.sv
module fce_seq_decoder
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [15:0]       wdata,
    output logic              cmd_fire,
    output op_e               cmd_op,
    output logic              is_idle
);
    dec_e state_q, state_n;

    logic at_a, at_b;
    logic [7:0] cb;

    assign at_a = (addr[15:0] == UNLOCK_ADR_A);
    assign at_b = (addr[15:0] == UNLOCK_ADR_B);
    assign cb   = wdata[7:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= D_IDLE;
        else        state_q <= state_n;
    end

    always_comb begin
        state_n  = state_q;
        cmd_fire = 1'b0;
        cmd_op   = OP_NONE;
        if (!en) begin
            state_n = D_IDLE;
        end else if (we) begin
            state_n = D_IDLE;
            unique case (state_q)
                D_IDLE: if (at_a && cb == KEY_A) state_n = D_UNL1;
                D_UNL1: if (at_b && cb == KEY_B) state_n = D_UNL2;
                D_UNL2: begin
                    if (at_a && cb == CMD_PROG)         state_n = D_PGM;
                    else if (at_a && cb == CMD_ERS_SET) state_n = D_ERS1;
                end
                D_PGM: begin
                    cmd_fire = 1'b1;
                    cmd_op   = OP_PROG;
                end
                D_ERS1: if (at_a && cb == KEY_A) state_n = D_ERS2;
                D_ERS2: if (at_b && cb == KEY_B) state_n = D_ERS3;
                D_ERS3: begin
                    if (at_a && cb == CMD_CHIP) begin
                        cmd_fire = 1'b1;
                        cmd_op   = OP_CHIP;
                    end else if (cb == CMD_SECT) begin
                        cmd_fire = 1'b1;
                        cmd_op   = OP_SECT;
                    end else if (cb == CMD_BLK) begin
                        cmd_fire = 1'b1;
                        cmd_op   = OP_BLK;
                    end
                end
                default: state_n = D_IDLE;
            endcase
        end
    end

    assign is_idle = (state_q == D_IDLE);

endmodule

// File: rtl/fce_op_ctrl.sv
module fce_op_ctrl
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int ARR_AW    = 4,
    parameter int SECT_W    = 2,
    parameter int BLK_W     = 1,
    parameter int PROG_CYC  = 6,
    parameter int ERASE_CYC = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [15:0]       wdata,
    input  logic              wp_n,
    input  logic              cmd_fire,
    input  op_e               cmd_op,
    input  logic              dec_idle,
    output logic              dec_en,
    output logic              busy,
    output logic              op_idle,
    output op_e               op_active,
    output logic              susp_active,
    output logic [SECT_W-1:0] susp_sector,
    output logic              pgm_apply,
    output logic [ARR_AW-1:0] pgm_idx,
    output logic [15:0]       pgm_data,
    output logic              ers_apply,
    output op_e               ers_op,
    output logic [SECT_W-1:0] ers_sect,
    output rdmode_e           rd_mode
);
    localparam int PCW = $clog2(PROG_CYC + 1);
    localparam int ECW = $clog2(ERASE_CYC + 1);

    ctl_e state_q, state_n;
    logic [PCW-1:0] pgm_cnt;
    logic [ECW-1:0] ers_cnt;

    logic [ARR_AW-1:0] a_idx;
    logic [SECT_W-1:0] a_sect;
    logic              a_hit;
    logic              go_prog;

    assign a_idx  = addr[ARR_AW-1:0];
    assign a_sect = a_idx[ARR_AW-1 -: SECT_W];
    assign a_hit  = (ers_op == OP_BLK) ?
                    (a_sect[SECT_W-1 -: BLK_W] == ers_sect[SECT_W-1 -: BLK_W]) :
                    (a_sect == ers_sect);
    assign go_prog = cmd_fire && (cmd_op == OP_PROG);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= C_IDLE;
        else        state_q <= state_n;
    end

    always_comb begin
        state_n = state_q;
        unique case (state_q)
            C_IDLE: begin
                if (go_prog) state_n = C_PROG;
                else if (cmd_fire && (cmd_op == OP_SECT || cmd_op == OP_BLK))
                    state_n = C_ERASE;
                else if (cmd_fire && cmd_op == OP_CHIP && wp_n)
                    state_n = C_ERASE;
            end
            C_PROG: if (pgm_cnt == '0) state_n = C_IDLE;
            C_ERASE: begin
                if (ers_cnt == '0)
                    state_n = C_IDLE;
                else if (we && wdata[7:0] == CMD_SUSPEND && ers_op != OP_CHIP)
                    state_n = C_SUSP;
            end
            C_SUSP: begin
                if (go_prog && !a_hit)
                    state_n = C_SUSP_PROG;
                else if (dec_idle && we && wdata[7:0] == CMD_RESUME)
                    state_n = C_ERASE;
            end
            C_SUSP_PROG: if (pgm_cnt == '0) state_n = C_SUSP;
            default: state_n = C_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pgm_cnt  <= '0;
            ers_cnt  <= '0;
            pgm_idx  <= '0;
            pgm_data <= '0;
            ers_op   <= OP_NONE;
            ers_sect <= '0;
        end else begin
            if ((state_q == C_IDLE && state_n == C_PROG) ||
                (state_q == C_SUSP && state_n == C_SUSP_PROG)) begin
                pgm_cnt  <= PCW'(PROG_CYC - 1);
                pgm_idx  <= a_idx;
                pgm_data <= wdata;
            end else if ((state_q == C_PROG || state_q == C_SUSP_PROG) && pgm_cnt != '0) begin
                pgm_cnt <= pgm_cnt - 1'b1;
            end
            if (state_q == C_IDLE && state_n == C_ERASE) begin
                ers_cnt  <= ECW'(ERASE_CYC - 1);
                ers_op   <= cmd_op;
                ers_sect <= a_sect;
            end else if (state_q == C_ERASE && state_n == C_ERASE) begin
                ers_cnt <= ers_cnt - 1'b1;
            end
        end
    end

    always_comb begin
        busy        = 1'b0;
        susp_active = 1'b0;
        op_active   = OP_NONE;
        rd_mode     = RM_ARRAY;
        pgm_apply   = 1'b0;
        ers_apply   = 1'b0;
        unique case (state_q)
            C_IDLE: ;
            C_PROG: begin
                busy      = 1'b1;
                op_active = OP_PROG;
                rd_mode   = RM_PROG;
                pgm_apply = (pgm_cnt == '0);
            end
            C_ERASE: begin
                busy      = 1'b1;
                op_active = ers_op;
                rd_mode   = RM_ERASE;
                ers_apply = (ers_cnt == '0);
            end
            C_SUSP: begin
                susp_active = 1'b1;
                op_active   = ers_op;
                rd_mode     = a_hit ? RM_SUSP_HIT : RM_ARRAY;
            end
            C_SUSP_PROG: begin
                busy        = 1'b1;
                susp_active = 1'b1;
                op_active   = OP_PROG;
                rd_mode     = RM_PROG;
                pgm_apply   = (pgm_cnt == '0);
            end
            default: ;
        endcase
    end

    assign dec_en      = (state_q == C_IDLE) || (state_q == C_SUSP);
    assign op_idle     = (state_q == C_IDLE);
    assign susp_sector = susp_active ? ers_sect : '0;

endmodule

// File: rtl/fce_word_array.sv
module fce_word_array
    import flash_cmd_pkg::*;
#(
    parameter int ARR_AW = 4,
    parameter int SECT_W = 2,
    parameter int BLK_W  = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pgm_en,
    input  logic [ARR_AW-1:0] pgm_idx,
    input  logic [15:0]       pgm_data,
    input  logic              ers_en,
    input  op_e               ers_op,
    input  logic [SECT_W-1:0] ers_sect,
    input  logic [ARR_AW-1:0] rd_idx,
    output logic [15:0]       rd_word
);
    localparam int DEPTH = 1 << ARR_AW;

    logic [15:0] mem [DEPTH];

    for (genvar w = 0; w < DEPTH; w++) begin : g_word
        localparam logic [ARR_AW-1:0] IDX = ARR_AW'(w);
        logic [SECT_W-1:0] my_sect;
        logic              wipe;
        assign my_sect = IDX[ARR_AW-1 -: SECT_W];
        assign wipe = ers_en && (
            (ers_op == OP_CHIP) ||
            (ers_op == OP_SECT && my_sect == ers_sect) ||
            (ers_op == OP_BLK  && my_sect[SECT_W-1 -: BLK_W] == ers_sect[SECT_W-1 -: BLK_W]));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                         mem[w] <= 16'hFFFF;
            else if (wipe)                      mem[w] <= 16'hFFFF;
            else if (pgm_en && pgm_idx == IDX)  mem[w] <= mem[w] & pgm_data;
        end
    end

    assign rd_word = mem[rd_idx];

endmodule

// File: rtl/fce_status_mux.sv
module fce_status_mux
    import flash_cmd_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rd_en,
    input  rdmode_e     rd_mode,
    input  logic        busy,
    input  logic        op_idle,
    input  logic        prog_d7,
    input  logic [15:0] arr_word,
    output logic [15:0] rdata
);
    logic t6_q, t2_q;
    logic [15:0] word_n;

    always_comb begin
        unique case (rd_mode)
            RM_ARRAY:    word_n = arr_word;
            RM_PROG:     word_n = {8'h00, ~prog_d7, t6_q, 3'b000, 1'b1, 2'b00};
            RM_ERASE:    word_n = {8'h00, 1'b0, t6_q, 3'b000, t2_q, 2'b00};
            RM_SUSP_HIT: word_n = {8'h00, 1'b1, 1'b1, 3'b000, t2_q, 2'b00};
            default:     word_n = arr_word;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata <= '0;
            t6_q  <= 1'b0;
            t2_q  <= 1'b0;
        end else begin
            if (rd_en) rdata <= word_n;
            if (!busy)
                t6_q <= 1'b0;
            else if (rd_en && (rd_mode == RM_PROG || rd_mode == RM_ERASE))
                t6_q <= ~t6_q;
            if (op_idle)
                t2_q <= 1'b0;
            else if (rd_en && (rd_mode == RM_ERASE || rd_mode == RM_SUSP_HIT))
                t2_q <= ~t2_q;
        end
    end

endmodule

// File: rtl/flash_cmd_engine.sv
module flash_cmd_engine
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int ARR_AW    = 4,
    parameter int SECT_W    = 2,
    parameter int BLK_W     = 1,
    parameter int PROG_CYC  = 6,
    parameter int ERASE_CYC = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic              bus_re,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [15:0]       bus_wdata,
    input  logic              wp_n,
    output logic [15:0]       bus_rdata,
    output logic              busy,
    output logic [2:0]        op_active,
    output logic              susp_active,
    output logic [SECT_W-1:0] susp_sector
);
    logic              dec_en, dec_idle, cmd_fire, op_idle;
    op_e               cmd_op, op_cur, ers_op;
    logic              pgm_apply, ers_apply;
    logic [ARR_AW-1:0] pgm_idx;
    logic [15:0]       pgm_data, arr_word;
    logic [SECT_W-1:0] ers_sect;
    rdmode_e           rd_mode;

    fce_seq_decoder #(.ADDR_W(ADDR_W)) u_dec (
        .clk(clk), .rst_n(rst_n), .en(dec_en), .we(bus_we),
        .addr(bus_addr), .wdata(bus_wdata),
        .cmd_fire(cmd_fire), .cmd_op(cmd_op), .is_idle(dec_idle)
    );

    fce_op_ctrl #(
        .ADDR_W(ADDR_W), .ARR_AW(ARR_AW), .SECT_W(SECT_W), .BLK_W(BLK_W),
        .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)
    ) u_ctl (
        .clk(clk), .rst_n(rst_n), .we(bus_we), .addr(bus_addr),
        .wdata(bus_wdata), .wp_n(wp_n), .cmd_fire(cmd_fire), .cmd_op(cmd_op),
        .dec_idle(dec_idle), .dec_en(dec_en), .busy(busy), .op_idle(op_idle),
        .op_active(op_cur), .susp_active(susp_active), .susp_sector(susp_sector),
        .pgm_apply(pgm_apply), .pgm_idx(pgm_idx), .pgm_data(pgm_data),
        .ers_apply(ers_apply), .ers_op(ers_op), .ers_sect(ers_sect),
        .rd_mode(rd_mode)
    );

    fce_word_array #(.ARR_AW(ARR_AW), .SECT_W(SECT_W), .BLK_W(BLK_W)) u_arr (
        .clk(clk), .rst_n(rst_n), .pgm_en(pgm_apply), .pgm_idx(pgm_idx),
        .pgm_data(pgm_data), .ers_en(ers_apply), .ers_op(ers_op),
        .ers_sect(ers_sect), .rd_idx(bus_addr[ARR_AW-1:0]), .rd_word(arr_word)
    );

    fce_status_mux u_stat (
        .clk(clk), .rst_n(rst_n), .rd_en(bus_re), .rd_mode(rd_mode),
        .busy(busy), .op_idle(op_idle), .prog_d7(pgm_data[7]),
        .arr_word(arr_word), .rdata(bus_rdata)
    );

    assign op_active = op_cur;

endmodule

// File: rtl/flash_cmd_engine_chk.sv
module flash_cmd_engine_chk #(
    parameter int SECT_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_re,
    input logic              wp_n,
    input logic [15:0]       bus_rdata,
    input logic              busy,
    input logic [2:0]        op_active,
    input logic              susp_active,
    input logic [SECT_W-1:0] susp_sector
);
    AST_SUSP_FROM_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(susp_active) |-> $past(busy)); // R10

    AST_SUSP_SECTOR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (susp_active && $past(susp_active)) |-> $stable(susp_sector)); // R10

    AST_WP_GATES_CHIP: assert property (@(posedge clk) disable iff (!rst_n)
        (op_active == 3'd4 && $past(op_active) != 3'd4) |-> $past(wp_n)); // R5

    AST_CHIP_NO_SUSPEND: assert property (@(posedge clk) disable iff (!rst_n)
        (op_active == 3'd4) |-> !susp_active); // R9

    AST_ERASE_DQ7_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $past(bus_re && busy && op_active >= 3'd2) |-> !bus_rdata[7]); // R8

    AST_PROG_DQ2_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        $past(bus_re && busy && op_active == 3'd1) |-> bus_rdata[2]); // R7

endmodule

bind flash_cmd_engine flash_cmd_engine_chk #(.SECT_W(SECT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_re(bus_re), .wp_n(wp_n),
    .bus_rdata(bus_rdata), .busy(busy), .op_active(op_active),
    .susp_active(susp_active), .susp_sector(susp_sector)
);

// File: tb/flash_cmd_engine_tb.sv
module flash_cmd_engine_tb;
    localparam int ADDR_W = 16, ARR_AW = 4, SECT_W = 2, BLK_W = 1;
    localparam int PROG_CYC = 6, ERASE_CYC = 20;
    localparam int DEPTH = 1 << ARR_AW;

    logic clk = 1'b0, rst_n = 1'b0, bus_we = 1'b0, bus_re = 1'b0, wp_n = 1'b1;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [15:0] bus_wdata = '0, bus_rdata;
    logic busy, susp_active;
    logic [2:0] op_active;
    logic [SECT_W-1:0] susp_sector;

    int total = 0, bad = 0;
    logic [15:0] mdl [DEPTH];

    always #5 clk = ~clk;

    flash_cmd_engine #(
        .ADDR_W(ADDR_W), .ARR_AW(ARR_AW), .SECT_W(SECT_W), .BLK_W(BLK_W),
        .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_re(bus_re),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .wp_n(wp_n),
        .bus_rdata(bus_rdata), .busy(busy), .op_active(op_active),
        .susp_active(susp_active), .susp_sector(susp_sector)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [15:0] d);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a, output logic [15:0] d);
        bus_re = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_re = 1'b0;
        d = bus_rdata;
    endtask

    task automatic seq_prog(input logic [15:0] a, input logic [15:0] d);
        wr(16'h5555, 16'h00AA); wr(16'h2AAA, 16'h0055);
        wr(16'h5555, 16'h00A0); wr(a, d);
    endtask

    task automatic seq_erase(input logic [15:0] a, input logic [15:0] c);
        wr(16'h5555, 16'h00AA); wr(16'h2AAA, 16'h0055); wr(16'h5555, 16'h0080);
        wr(16'h5555, 16'h00AA); wr(16'h2AAA, 16'h0055); wr(a, c);
    endtask

    task automatic wait_idle(output int n);
        n = 0;
        while (busy && n < 1000) begin n++; @(negedge clk); end
    endtask

    task automatic check_all(input string req);
        logic [15:0] v;
        for (int i = 0; i < DEPTH; i++) begin
            rd(16'(i), v);
            chk(req, {16'h0, v}, {16'h0, mdl[i]});
        end
    endtask

    initial begin
        #2_000_000;
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [15:0] v, v2;
        int n;
        for (int i = 0; i < DEPTH; i++) mdl[i] = 16'hFFFF;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R13 reset state and idle reads
        chk("R13 busy", {31'h0, busy}, 0);
        chk("R13 susp", {31'h0, susp_active}, 0);
        chk("R13 op", {29'h0, op_active}, 0);
        check_all("R13 reset array");

        // R1 program sweep over every word
        for (int i = 0; i < DEPTH; i++) begin
            logic [15:0] d;
            d = ~(16'h0001 << i) ^ 16'(i << 8);
            seq_prog(16'(i), d);
            chk("R1 op", {29'h0, op_active}, 1);
            wait_idle(n);
            chk("R1 duration", n, PROG_CYC);
            mdl[i] = mdl[i] & d;
        end
        check_all("R1 program result");

        // R7 program status, both values of data bit 7
        seq_prog(16'h0001, 16'hFF7F);
        rd(16'h0001, v); chk("R7 first status", {16'h0, v}, 32'h0084);
        rd(16'h0001, v); chk("R7 second status", {16'h0, v}, 32'h00C4);
        rd(16'h0001, v); chk("R7 third status", {16'h0, v}, 32'h0084);
        wait_idle(n);
        mdl[1] = mdl[1] & 16'hFF7F;
        seq_prog(16'h0002, 16'h0080);
        rd(16'h0002, v); chk("R7 d7 set first", {16'h0, v}, 32'h0004);
        rd(16'h0002, v); chk("R7 d7 set second", {16'h0, v}, 32'h0044);
        wait_idle(n);
        mdl[2] = mdl[2] & 16'h0080;
        rd(16'h0002, v); chk("R7 after done", {16'h0, v}, {16'h0, mdl[2]});

        // R6 broken sequence has no effect
        wr(16'h5555, 16'h00AA); wr(16'h2AAA, 16'h0055); wr(16'h5555, 16'h0012);
        wr(16'h5555, 16'h00A0); wr(16'h0003, 16'h0000);
        @(negedge clk);
        chk("R6 no busy", {31'h0, busy}, 0);
        wr(16'h5555, 16'h00AA); wr(16'h1234, 16'h0055);
        wr(16'h5555, 16'h00A0); wr(16'h0004, 16'h0000);
        @(negedge clk);
        chk("R6 wrong address no busy", {31'h0, busy}, 0);
        check_all("R6 array unchanged");

        // R2 sector erase of sector 2
        seq_erase(16'h0009, 16'h0030);
        chk("R2 op", {29'h0, op_active}, 2);
        wait_idle(n);
        chk("R2 duration", n, ERASE_CYC);
        for (int i = 8; i < 12; i++) mdl[i] = 16'hFFFF;
        check_all("R2 sector erased");

        // R8 erase status on sector 0
        seq_erase(16'h0000, 16'h0030);
        rd(16'h0000, v); chk("R8 first status", {16'h0, v}, 32'h0000);
        rd(16'h0000, v); chk("R8 second status", {16'h0, v}, 32'h0044);
        rd(16'h0000, v); chk("R8 third status", {16'h0, v}, 32'h0000);
        wait_idle(n);
        for (int i = 0; i < 4; i++) mdl[i] = 16'hFFFF;
        rd(16'h0000, v); chk("R8 dq7 high after", {31'h0, v[7]}, 1);

        // R3 block erase of block 1 (words 8..15)
        seq_erase(16'h000D, 16'h0050);
        chk("R3 op", {29'h0, op_active}, 3);
        wait_idle(n);
        chk("R3 duration", n, ERASE_CYC);
        for (int i = 8; i < 16; i++) mdl[i] = 16'hFFFF;
        check_all("R3 block erased");

        // R5 whole-array erase blocked by write protect
        seq_prog(16'h0005, 16'h5A5A); wait_idle(n); mdl[5] = mdl[5] & 16'h5A5A;
        wp_n = 1'b0;
        seq_erase(16'h5555, 16'h0010);
        @(negedge clk);
        chk("R5 no busy", {31'h0, busy}, 0);
        chk("R5 op none", {29'h0, op_active}, 0);
        wp_n = 1'b1;
        check_all("R5 array kept");

        // R4 and R9 whole-array erase ignoring writes
        seq_erase(16'h5555, 16'h0010);
        chk("R4 op", {29'h0, op_active}, 4);
        wr(16'h0000, 16'h00B0);
        chk("R9 still busy", {31'h0, busy}, 1);
        chk("R9 no suspend", {31'h0, susp_active}, 0);
        seq_prog(16'h0003, 16'h0000);
        wait_idle(n);
        chk("R9 remaining", n, ERASE_CYC - 5);
        for (int i = 0; i < DEPTH; i++) mdl[i] = 16'hFFFF;
        check_all("R4 all erased");

        // R10 R11 R12 suspend and resume
        seq_prog(16'h0004, 16'h1111); wait_idle(n); mdl[4] = 16'h1111;
        seq_prog(16'h0000, 16'h2222); wait_idle(n); mdl[0] = 16'h2222;
        seq_erase(16'h0005, 16'h0030);
        repeat (3) @(negedge clk);
        wr(16'h0000, 16'h00B0);
        chk("R10 busy low", {31'h0, busy}, 0);
        chk("R10 susp high", {31'h0, susp_active}, 1);
        chk("R10 sector", {30'h0, susp_sector}, 1);
        rd(16'h0005, v); chk("R10 hit first", {16'h0, v}, 32'h00C0);
        rd(16'h0006, v); chk("R10 hit second", {16'h0, v}, 32'h00C4);
        rd(16'h0000, v); chk("R10 outside read", {16'h0, v}, 32'h2222);
        seq_prog(16'h0006, 16'h0000);
        @(negedge clk);
        chk("R12 inside ignored", {31'h0, busy}, 0);
        seq_prog(16'h0009, 16'h0F0F);
        chk("R12 busy", {31'h0, busy}, 1);
        rd(16'h0009, v); rd(16'h0009, v2);
        chk("R12 status first", {16'h0, v}, 32'h0084);
        chk("R12 status second", {16'h0, v2}, 32'h00C4);
        wait_idle(n);
        chk("R12 back to suspend", {31'h0, susp_active}, 1);
        mdl[9] = 16'h0F0F;
        rd(16'h0009, v); chk("R12 programmed", {16'h0, v}, 32'h0F0F);
        wr(16'h1234, 16'h0030);
        chk("R11 resumed", {31'h0, busy}, 1);
        wait_idle(n);
        chk("R11 remaining", n, ERASE_CYC - 3);
        chk("R11 susp cleared", {31'h0, susp_active}, 0);
        for (int i = 4; i < 8; i++) mdl[i] = 16'hFFFF;
        check_all("R11 final array");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule